// File: doc/BRIEF.md
# Host Register Hub with Buffered Memory Writes

This block sits behind the host link and turns decoded single-beat requests into actions on the display side. Each request names either the register space or the memory space, a word address, write data and four byte enables. Register-space accesses to the display timing settings are passed through an 8-bit register port with select lines, so those settings live only in the timing unit. A small bank of general registers and a retrace status word are held locally. A window of register addresses covering glyph and palette storage is steered to memory instead of the timing port.

Every memory-bound write is pushed into an external write FIFO, so a burst of host writes is absorbed without waiting on memory arbitration. Memory-bound reads go out on a direct-read request path and complete when the memory side returns the word. So that a read can never overtake a buffered write to the same location, the hub answers every read with a retry while the write FIFO holds data or a push may still be in flight. The host repeats the request until it is accepted. A write that finds the FIFO full is also answered with a retry.

Top module: `host_reg_hub`

## Requirements
- R1: A memory-space write accepted while `wf_full` is low produces a one-cycle `wf_push` carrying the request address, data and byte enables, and an acknowledge (`rsp_valid` high, `rsp_retry` low), both one cycle after acceptance.
- R2: Any read (either space, any register) accepted while `wf_empty` is low, or within `PUSH_HOLD` cycles after a push, is answered with `rsp_retry` high and has no other effect; once the FIFO is empty and the hold has run out, the same read succeeds.
- R3: A memory-space read that is not refused raises `dr_req` for one cycle with `dr_addr` equal to the request address; the response carries `dr_data` one cycle after `dr_valid`.
- R4: A register write to word index 0 to 15 raises `tbus_wr` for one cycle with `tbus_sel` equal to the index and `tbus_wdata` equal to write data bits 7:0, only when byte enable bit 0 is set; nothing is stored in the hub.
- R5: A register read of word index 0 to 15 raises `tbus_rd` with `tbus_sel` equal to the index and returns `tbus_rdata` zero-extended to 32 bits.
- R6: Register word indexes 0x80 to 0xFF form the glyph and palette window: writes are pushed to the FIFO at address `GLYPH_BASE` plus index bits 6:0 and never strobe the timing port; reads go out as direct reads to that same address.
- R7: Register word indexes 0x10 to 0x17 are eight 32-bit general registers that reset to zero; a write updates only the byte lanes whose enable bit is set, and a read returns the stored word.
- R8: Register word index 0x20 reads as status: bit 0 is the sampled retrace level, bit 1 is set when retrace rises and cleared by a successful status read; writes to it have no effect.
- R9: A memory-bound write that finds `wf_full` high is answered with a retry and produces no push.
- R10: A register read of any index outside the ranges above returns zero, and a write to it has no effect.
- R11: `req_ready` is high exactly when the hub holds no request in progress; a request waiting on the timing port or on memory holds it low.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present, taken when `req_ready` is high |
| req_ready | output | 1 | Hub can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory space, 0 = register space |
| req_addr | input | ADDR_W | Word address (register index in bits 7:0) |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| rsp_valid | output | 1 | Response for the last request |
| rsp_retry | output | 1 | Request refused, to be repeated |
| rsp_rdata | output | 32 | Read data |
| tbus_wr | output | 1 | Timing register write strobe |
| tbus_rd | output | 1 | Timing register read strobe |
| tbus_sel | output | SEL_W | Timing register select |
| tbus_wdata | output | 8 | Timing register write byte |
| tbus_rdata | input | 8 | Timing register read byte, valid while `tbus_rd` is high |
| retrace_in | input | 1 | Retrace level from the timing unit |
| wf_push | output | 1 | Write FIFO push |
| wf_addr | output | ADDR_W | Pushed address |
| wf_data | output | 32 | Pushed data |
| wf_be | output | 4 | Pushed byte enables |
| wf_full | input | 1 | Write FIFO full |
| wf_empty | input | 1 | Write FIFO empty |
| dr_req | output | 1 | Direct read request |
| dr_addr | output | ADDR_W | Direct read address |
| dr_valid | input | 1 | Direct read data present |
| dr_data | input | 32 | Direct read data |

## Verification
The bound checker watches, on every cycle, that a direct read is only ever issued while the write FIFO is empty, that a push never meets a full FIFO, that the timing port never reads and writes at once, that a direct read address holds while the read is open and that responses, timing reads and direct-read requests never coincide. The correctness of returned values, the byte-lane merging of the general registers, the sticky retrace bit, the glyph window address translation and the retry-then-succeed sequence after a buffered write can only be shown by the bench scenarios, which compare every response against models of the FIFO, the memory and the timing unit.

// File: rtl/hrf_pkg.sv
package hrf_pkg;

    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TIM_RD,
        ST_MEM_RD
    } hub_state_e;

    typedef enum logic [2:0] {
        RG_TIMING,
        RG_LOCAL,
        RG_STATUS,
        RG_GLYPH,
        RG_MEM,
        RG_NONE
    } region_e;

endpackage

// File: rtl/hrf_decode.sv
module hrf_decode
    import hrf_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                REG_AW     = 8,
    parameter int                SEL_W      = 4,
    parameter int                N_LOCAL    = 8,
    parameter int                LOCAL_BASE = 16,
    parameter int                STATUS_IDX = 32,
    parameter int                GLYPH_AW   = 7,
    parameter logic [ADDR_W-1:0] GLYPH_BASE = 16'hF000,
    localparam int               LIDX_W     = (N_LOCAL > 1) ? $clog2(N_LOCAL) : 1
) (
    input  logic              is_mem,
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [SEL_W-1:0]  sel,
    output logic [LIDX_W-1:0] local_idx,
    output logic [ADDR_W-1:0] mem_addr
);

    localparam logic [REG_AW:0] TIM_END   = (REG_AW+1)'(2 ** SEL_W);
    localparam logic [REG_AW:0] LOC_LO    = (REG_AW+1)'(LOCAL_BASE);
    localparam logic [REG_AW:0] LOC_HI    = (REG_AW+1)'(LOCAL_BASE + N_LOCAL);
    localparam logic [REG_AW:0] STAT_IDX  = (REG_AW+1)'(STATUS_IDX);
    localparam logic [REG_AW:0] GLYPH_LO  = (REG_AW+1)'(2 ** REG_AW - 2 ** GLYPH_AW);

    logic [REG_AW:0] idx;
    logic [REG_AW:0] loc_off;

    assign idx     = {1'b0, addr[REG_AW-1:0]};
    assign loc_off = idx - LOC_LO;

    always_comb begin
        region    = RG_NONE;
        sel       = addr[SEL_W-1:0];
        local_idx = loc_off[LIDX_W-1:0];
        mem_addr  = addr;
        if (is_mem) begin
            region = RG_MEM;
        end else if (idx < TIM_END) begin
            region = RG_TIMING;
        end else if (idx >= LOC_LO && idx < LOC_HI) begin
            region = RG_LOCAL;
        end else if (idx == STAT_IDX) begin
            region = RG_STATUS;
        end else if (idx >= GLYPH_LO) begin
            region   = RG_GLYPH;
            mem_addr = GLYPH_BASE + ADDR_W'(addr[GLYPH_AW-1:0]);
        end
    end

endmodule

// File: rtl/hrf_local_regs.sv
module hrf_local_regs
    import hrf_pkg::*;
#(
    parameter int  N_LOCAL = 8,
    localparam int LIDX_W  = (N_LOCAL > 1) ? $clog2(N_LOCAL) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LIDX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [LIDX_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] words [N_LOCAL];

    for (genvar gi = 0; gi < N_LOCAL; gi++) begin : g_word
        logic [DATA_W-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (wr_en && wr_idx == LIDX_W'(gi)) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (wr_be[b]) word_d[b*8 +: 8] = wr_data[b*8 +: 8];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end

        assign words[gi] = word_q;
    end

    assign rd_data = words[rd_idx];

endmodule

// File: rtl/hrf_retrace_status.sv
module hrf_retrace_status (
    input  logic clk,
    input  logic rst_n,
    input  logic retrace_in,
    input  logic clr,
    output logic live,
    output logic seen
);

    typedef struct packed {
        logic live;
        logic seen;
    } rs_t;

    rs_t rs_d, rs_q;

    always_comb begin
        rs_d      = rs_q;
        rs_d.live = retrace_in;
        rs_d.seen = (retrace_in && !rs_q.live) || (rs_q.seen && !clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign live = rs_q.live;
    assign seen = rs_q.seen;

endmodule

// File: rtl/host_reg_hub.sv
module host_reg_hub
    import hrf_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                SEL_W      = 4,
    parameter int                N_LOCAL    = 8,
    parameter int                PUSH_HOLD  = 3,
    parameter logic [ADDR_W-1:0] GLYPH_BASE = 16'hF000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_mem,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        req_be,
    output logic              rsp_valid,
    output logic              rsp_retry,
    output logic [31:0]       rsp_rdata,
    output logic              tbus_wr,
    output logic              tbus_rd,
    output logic [SEL_W-1:0]  tbus_sel,
    output logic [7:0]        tbus_wdata,
    input  logic [7:0]        tbus_rdata,
    input  logic              retrace_in,
    output logic              wf_push,
    output logic [ADDR_W-1:0] wf_addr,
    output logic [31:0]       wf_data,
    output logic [3:0]        wf_be,
    input  logic              wf_full,
    input  logic              wf_empty,
    output logic              dr_req,
    output logic [ADDR_W-1:0] dr_addr,
    input  logic              dr_valid,
    input  logic [31:0]       dr_data
);

    localparam int REG_AW   = 8;
    localparam int GLYPH_AW = 7;
    localparam int LIDX_W   = (N_LOCAL > 1) ? $clog2(N_LOCAL) : 1;
    localparam int HOLD_W   = $clog2(PUSH_HOLD + 1);
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(PUSH_HOLD);

    typedef struct packed {
        hub_state_e        st;
        logic              rsp_valid;
        logic              rsp_retry;
        logic [DATA_W-1:0] rsp_data;
        logic              t_wr;
        logic              t_rd;
        logic [SEL_W-1:0]  t_sel;
        logic [7:0]        t_data;
        logic              push;
        logic [ADDR_W-1:0] p_addr;
        logic [DATA_W-1:0] p_data;
        logic [BE_W-1:0]   p_be;
        logic              d_req;
        logic [ADDR_W-1:0] d_addr;
        logic [HOLD_W-1:0] hold;
    } hub_t;

    hub_t hub_d, hub_q;

    region_e           region;
    logic [SEL_W-1:0]  dec_sel;
    logic [LIDX_W-1:0] dec_lidx;
    logic [ADDR_W-1:0] dec_maddr;
    logic [DATA_W-1:0] loc_rdata;
    logic              ret_live, ret_seen;
    logic              accept, blocked;
    logic              loc_wr, stat_clr;

    hrf_decode #(
        .ADDR_W    (ADDR_W),
        .REG_AW    (REG_AW),
        .SEL_W     (SEL_W),
        .N_LOCAL   (N_LOCAL),
        .LOCAL_BASE(16),
        .STATUS_IDX(32),
        .GLYPH_AW  (GLYPH_AW),
        .GLYPH_BASE(GLYPH_BASE)
    ) u_decode (
        .is_mem   (req_mem),
        .addr     (req_addr),
        .region   (region),
        .sel      (dec_sel),
        .local_idx(dec_lidx),
        .mem_addr (dec_maddr)
    );

    assign accept   = req_valid && (hub_q.st == ST_IDLE);
    assign blocked  = !wf_empty || (hub_q.hold != '0);
    assign loc_wr   = accept && req_write && (region == RG_LOCAL);
    assign stat_clr = accept && !req_write && !blocked && (region == RG_STATUS);

    hrf_local_regs #(
        .N_LOCAL(N_LOCAL)
    ) u_local (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (loc_wr),
        .wr_idx (dec_lidx),
        .wr_data(req_wdata),
        .wr_be  (req_be),
        .rd_idx (dec_lidx),
        .rd_data(loc_rdata)
    );

    hrf_retrace_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .retrace_in(retrace_in),
        .clr       (stat_clr),
        .live      (ret_live),
        .seen      (ret_seen)
    );

    always_comb begin
        hub_d           = hub_q;
        hub_d.rsp_valid = 1'b0;
        hub_d.rsp_retry = 1'b0;
        hub_d.t_wr      = 1'b0;
        hub_d.t_rd      = 1'b0;
        hub_d.push      = 1'b0;
        hub_d.d_req     = 1'b0;
        if (hub_q.hold != '0) hub_d.hold = hub_q.hold - 1'b1;

        unique case (hub_q.st)
            ST_IDLE: begin
                if (accept) begin
                    hub_d.rsp_data = '0;
                    if (req_write) begin
                        hub_d.rsp_valid = 1'b1;
                        unique case (region)
                            RG_MEM, RG_GLYPH: begin
                                if (wf_full) begin
                                    hub_d.rsp_retry = 1'b1;
                                end else begin
                                    hub_d.push   = 1'b1;
                                    hub_d.p_addr = dec_maddr;
                                    hub_d.p_data = req_wdata;
                                    hub_d.p_be   = req_be;
                                    hub_d.hold   = HOLD_LOAD;
                                end
                            end
                            RG_TIMING: begin
                                if (req_be[0]) begin
                                    hub_d.t_wr   = 1'b1;
                                    hub_d.t_sel  = dec_sel;
                                    hub_d.t_data = req_wdata[7:0];
                                end
                            end
                            default: ;
                        endcase
                    end else if (blocked) begin
                        hub_d.rsp_valid = 1'b1;
                        hub_d.rsp_retry = 1'b1;
                    end else begin
                        unique case (region)
                            RG_TIMING: begin
                                hub_d.t_rd  = 1'b1;
                                hub_d.t_sel = dec_sel;
                                hub_d.st    = ST_TIM_RD;
                            end
                            RG_MEM, RG_GLYPH: begin
                                hub_d.d_req  = 1'b1;
                                hub_d.d_addr = dec_maddr;
                                hub_d.st     = ST_MEM_RD;
                            end
                            RG_LOCAL: begin
                                hub_d.rsp_valid = 1'b1;
                                hub_d.rsp_data  = loc_rdata;
                            end
                            RG_STATUS: begin
                                hub_d.rsp_valid = 1'b1;
                                hub_d.rsp_data  = {{(DATA_W-2){1'b0}}, ret_seen, ret_live};
                            end
                            default: begin
                                hub_d.rsp_valid = 1'b1;
                            end
                        endcase
                    end
                end
            end
            ST_TIM_RD: begin
                hub_d.rsp_valid = 1'b1;
                hub_d.rsp_data  = {{(DATA_W-8){1'b0}}, tbus_rdata};
                hub_d.st        = ST_IDLE;
            end
            ST_MEM_RD: begin
                if (dr_valid) begin
                    hub_d.rsp_valid = 1'b1;
                    hub_d.rsp_data  = dr_data;
                    hub_d.st        = ST_IDLE;
                end
            end
            default: hub_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hub_q <= '0;
        else        hub_q <= hub_d;
    end

    assign req_ready  = (hub_q.st == ST_IDLE);
    assign rsp_valid  = hub_q.rsp_valid;
    assign rsp_retry  = hub_q.rsp_retry;
    assign rsp_rdata  = hub_q.rsp_data;
    assign tbus_wr    = hub_q.t_wr;
    assign tbus_rd    = hub_q.t_rd;
    assign tbus_sel   = hub_q.t_sel;
    assign tbus_wdata = hub_q.t_data;
    assign wf_push    = hub_q.push;
    assign wf_addr    = hub_q.p_addr;
    assign wf_data    = hub_q.p_data;
    assign wf_be      = hub_q.p_be;
    assign dr_req     = hub_q.d_req;
    assign dr_addr    = hub_q.d_addr;

endmodule

// File: rtl/host_reg_hub_chk.sv
module host_reg_hub_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rsp_valid,
    input logic              tbus_wr,
    input logic              tbus_rd,
    input logic              wf_push,
    input logic              wf_full,
    input logic              wf_empty,
    input logic              dr_req,
    input logic [ADDR_W-1:0] dr_addr
);

    // R2: a direct read goes out only when no buffered write is pending
    a_r2_read_only_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
        dr_req |-> wf_empty);

    // R9: a push never meets a full FIFO
    a_r9_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        wf_push |-> !wf_full);

    // R4 / R5: timing port never reads and writes together
    a_r4_tbus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tbus_wr && tbus_rd));

    // R3: a direct read request is a single pulse and its address holds afterwards
    a_r3_dr_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dr_req |=> !dr_req);

    a_r3_dr_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        dr_req |=> $stable(dr_addr));

    // R11: one request in progress at a time
    a_r11_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid, tbus_rd, dr_req}));

endmodule

bind host_reg_hub host_reg_hub_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rsp_valid(rsp_valid),
    .tbus_wr  (tbus_wr),
    .tbus_rd  (tbus_rd),
    .wf_push  (wf_push),
    .wf_full  (wf_full),
    .wf_empty (wf_empty),
    .dr_req   (dr_req),
    .dr_addr  (dr_addr)
);

// File: tb/host_reg_hub_test.sv
module host_reg_hub_test;

    localparam int ADDR_W     = 16;
    localparam int SEL_W      = 4;
    localparam int FIFO_DEPTH = 4;
    localparam logic [15:0] GBASE = 16'hF000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [3:0]        req_be = '0;
    logic              req_ready, rsp_valid, rsp_retry;
    logic [31:0]       rsp_rdata;
    logic              tbus_wr, tbus_rd;
    logic [SEL_W-1:0]  tbus_sel;
    logic [7:0]        tbus_wdata, tbus_rdata;
    logic              retrace_in = 1'b0;
    logic              wf_push, wf_full, wf_empty;
    logic [ADDR_W-1:0] wf_addr, dr_addr;
    logic [31:0]       wf_data, dr_data;
    logic [3:0]        wf_be;
    logic              dr_req, dr_valid;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    host_reg_hub uut (.*);

    // ---------------- models ----------------
    function automatic logic [7:0] tim_val(logic [SEL_W-1:0] s);
        return 8'h5A ^ {s, s};
    endfunction

    function automatic logic [31:0] mem_val(logic [15:0] a);
        return {a, a ^ 16'hBEEF};
    endfunction

    function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    assign tbus_rdata = tim_val(tbus_sel);

    int   fifo_count = 0;
    logic drain_en = 1'b1;
    assign wf_empty = (fifo_count == 0);
    assign wf_full  = (fifo_count >= FIFO_DEPTH);

    always @(posedge clk) begin
        int n;
        n = fifo_count;
        if (wf_push) n++;
        if (drain_en && fifo_count > 0) n--;
        fifo_count <= n;
    end

    int          mem_cnt = 0;
    logic [15:0] mem_a = '0;
    logic        mv = 1'b0;
    logic [31:0] md = '0;
    assign dr_valid = mv;
    assign dr_data  = md;

    always @(posedge clk) begin
        mv <= 1'b0;
        if (dr_req) begin
            mem_cnt <= 3;
            mem_a   <= dr_addr;
        end else if (mem_cnt > 0) begin
            mem_cnt <= mem_cnt - 1;
            if (mem_cnt == 1) begin
                mv <= 1'b1;
                md <= mem_val(mem_a);
            end
        end
    end

    // ---------------- helpers ----------------
    logic        r_retry;
    logic [31:0] r_data;
    logic        s_push, s_twr;
    logic [15:0] s_paddr;
    logic [31:0] s_pdata;
    logic [3:0]  s_pbe;
    logic [3:0]  s_tsel;
    logic [7:0]  s_tdata;
    logic        s_ready_busy;

    task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic mem, input logic wr, input logic [15:0] a,
                         input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_mem = mem;
        req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 1'b0;
        s_ready_busy = 1'b0;
        while (!rsp_valid) begin
            if (!req_ready) s_ready_busy = 1'b1;
            @(negedge clk);
        end
        r_retry = rsp_retry; r_data = rsp_rdata;
        s_push = wf_push; s_paddr = wf_addr; s_pdata = wf_data; s_pbe = wf_be;
        s_twr = tbus_wr; s_tsel = tbus_sel; s_tdata = tbus_wdata;
    endtask

    task automatic read_until_ok(input logic mem, input logic [15:0] a);
        int tries = 0;
        do begin
            issue(mem, 1'b0, a, '0, '0);
            tries++;
        end while (r_retry && tries < 50);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    logic [31:0] shadow [8];

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h1234ABCD);
        for (int i = 0; i < 8; i++) shadow[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // reset state
        check(req_ready && !rsp_valid && !wf_push && !tbus_wr && !dr_req, "R11 reset outputs",
              {28'd0, req_ready, rsp_valid, wf_push, tbus_wr}, 32'h8);
        for (int i = 0; i < 8; i++) begin
            issue(1'b0, 1'b0, 16'h10 + 16'(i), '0, '0);
            check(!r_retry && r_data == 32'd0, "R7 local reset zero", r_data, 32'd0);
        end

        // R7: byte-lane writes
        issue(1'b0, 1'b1, 16'h12, 32'hA1B2C3D4, 4'b1111);
        issue(1'b0, 1'b1, 16'h12, 32'h11223344, 4'b0101);
        issue(1'b0, 1'b0, 16'h12, '0, '0);
        check(r_data == 32'hA122C344, "R7 byte enable merge", r_data, 32'hA122C344);
        shadow[2] = 32'hA122C344;

        // R4: timing write forwarded, not stored
        issue(1'b0, 1'b1, 16'h0003, 32'h123456A7, 4'b0001);
        check(s_twr && s_tsel == 4'd3 && s_tdata == 8'hA7, "R4 timing write strobe",
              {20'd0, s_twr, s_tsel, s_tdata}, {20'd0, 1'b1, 4'd3, 8'hA7});
        check(!s_push, "R4 timing write not pushed", {31'd0, s_push}, 32'd0);
        issue(1'b0, 1'b1, 16'h0005, 32'h000000FF, 4'b1110);
        check(!s_twr, "R4 no strobe without lane 0", {31'd0, s_twr}, 32'd0);

        // R5: timing read
        issue(1'b0, 1'b0, 16'h0003, '0, '0);
        check(!r_retry && r_data == {24'd0, tim_val(4'd3)}, "R5 timing read", r_data, {24'd0, tim_val(4'd3)});
        check(s_ready_busy, "R11 busy during timing read", {31'd0, s_ready_busy}, 32'd1);

        // R10: unmapped
        issue(1'b0, 1'b1, 16'h0030, 32'hFFFFFFFF, 4'b1111);
        issue(1'b0, 1'b0, 16'h0030, '0, '0);
        check(!r_retry && r_data == 32'd0, "R10 unmapped reads zero", r_data, 32'd0);

        // R8: status
        issue(1'b0, 1'b1, 16'h0020, 32'hFFFFFFFF, 4'b1111);
        issue(1'b0, 1'b0, 16'h0020, '0, '0);
        check(r_data == 32'd0, "R8 status idle, write ignored", r_data, 32'd0);
        @(negedge clk); retrace_in = 1'b1;
        repeat (3) @(negedge clk);
        issue(1'b0, 1'b0, 16'h0020, '0, '0);
        check(r_data == 32'd3, "R8 status live and sticky", r_data, 32'd3);
        issue(1'b0, 1'b0, 16'h0020, '0, '0);
        check(r_data == 32'd1, "R8 sticky cleared by read", r_data, 32'd1);
        @(negedge clk); retrace_in = 1'b0;
        repeat (3) @(negedge clk);
        issue(1'b0, 1'b0, 16'h0020, '0, '0);
        check(r_data == 32'd0, "R8 status after retrace", r_data, 32'd0);

        // R1: memory write push
        issue(1'b1, 1'b1, 16'h4321, 32'hCAFEF00D, 4'b1011);
        check(!r_retry && s_push && s_paddr == 16'h4321 && s_pdata == 32'hCAFEF00D && s_pbe == 4'b1011,
              "R1 memory write push", s_pdata, 32'hCAFEF00D);

        // R2: read straight after a write is refused even while draining
        issue(1'b1, 1'b0, 16'h0100, '0, '0);
        check(r_retry, "R2 read after write refused", {31'd0, r_retry}, 32'd1);
        read_until_ok(1'b1, 16'h0100);
        check(!r_retry && r_data == mem_val(16'h0100), "R2 R3 read accepted later", r_data, mem_val(16'h0100));

        // R2 / R9 with FIFO held
        @(negedge clk); drain_en = 1'b0;
        issue(1'b1, 1'b1, 16'h0200, 32'h1, 4'hF);
        repeat (10) @(negedge clk);
        issue(1'b1, 1'b0, 16'h0200, '0, '0);
        check(r_retry, "R2 memory read refused while FIFO holds data", {31'd0, r_retry}, 32'd1);
        issue(1'b0, 1'b0, 16'h0012, '0, '0);
        check(r_retry, "R2 register read refused while FIFO holds data", {31'd0, r_retry}, 32'd1);
        for (int i = 0; i < FIFO_DEPTH - 1; i++) issue(1'b1, 1'b1, 16'h0201 + 16'(i), 32'h2, 4'hF);
        issue(1'b1, 1'b1, 16'h0300, 32'h3, 4'hF);
        check(r_retry && !s_push, "R9 write refused when full", {30'd0, r_retry, s_push}, 32'h2);
        @(negedge clk); drain_en = 1'b1;
        while (fifo_count != 0) @(negedge clk);
        repeat (6) @(negedge clk);
        issue(1'b1, 1'b0, 16'h0777, '0, '0);
        check(!r_retry && r_data == mem_val(16'h0777), "R3 direct read data", r_data, mem_val(16'h0777));
        check(s_ready_busy, "R11 busy during memory read", {31'd0, s_ready_busy}, 32'd1);

        // R6: glyph window
        issue(1'b0, 1'b1, 16'h0085, 32'h00C0FFEE, 4'b0011);
        check(s_push && s_paddr == (GBASE + 16'h5) && s_pbe == 4'b0011 && !s_twr,
              "R6 glyph write redirected", {16'd0, s_paddr}, {16'd0, GBASE + 16'h5});
        read_until_ok(1'b0, 16'h00FF);
        check(!r_retry && r_data == mem_val(GBASE + 16'h7F), "R6 glyph read direct", r_data, mem_val(GBASE + 16'h7F));

        // random mix
        for (int it = 0; it < 200; it++) begin
            int op;
            logic [15:0] a;
            logic [31:0] d;
            logic [3:0]  be;
            op = int'($urandom_range(0, 4));
            d  = $urandom;
            be = 4'($urandom_range(0, 15));
            case (op)
                0: begin
                    a = 16'h10 + 16'($urandom_range(0, 7));
                    issue(1'b0, 1'b1, a, d, be);
                    shadow[a - 16'h10] = merge(shadow[a - 16'h10], d, be);
                end
                1: begin
                    a = 16'h10 + 16'($urandom_range(0, 7));
                    read_until_ok(1'b0, a);
                    check(r_data == shadow[a - 16'h10], "R7 random local read", r_data, shadow[a - 16'h10]);
                end
                2: begin
                    a = 16'($urandom_range(0, 15));
                    issue(1'b0, 1'b1, a, d, be);
                    check(s_twr == be[0] && (!be[0] || (s_tsel == a[3:0] && s_tdata == d[7:0])),
                          "R4 random timing write", {23'd0, s_twr, s_tdata}, {23'd0, be[0], d[7:0]});
                end
                3: begin
                    a = 16'($urandom);
                    read_until_ok(1'b1, a);
                    check(!r_retry && r_data == mem_val(a), "R3 random memory read", r_data, mem_val(a));
                end
                default: begin
                    a = 16'($urandom);
                    issue(1'b1, 1'b1, a, d, be);
                    check(!r_retry && s_push && s_paddr == a && s_pdata == d && s_pbe == be,
                          "R1 random memory write", s_pdata, d);
                end
            endcase
        end

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule